// File: doc/BRIEF.md
# Bit-Serial Relational Search Memory

This block keeps a small table of stored words and compares every one of them against a reference word at the same time. It works on one bit position per cycle, starting from the most significant bit. For each word and each bit position it forms a two-flag code. Three gates turn that code into a per-bit verdict: equal, reference-below or reference-above. Each word keeps its own small order state, which moves out of "undecided" at the first bit that differs and then stays fixed.

A host loads words one at a time through the write port. It then pulses the search start together with a reference word. After the scan it reads three per-word vectors, framed by a one-cycle done strobe: equal, reference-less-than-stored and reference-greater-than-stored. Words that were never written report nothing. The control is a three-state machine:

- `ST_IDLE` accepts writes and search starts. On a start it moves to `ST_SCAN`.
- `ST_SCAN` visits the bit positions from the top bit down. After bit 0 it moves to `ST_RESULT`.
- `ST_RESULT` registers the vectors and the done strobe, then returns to `ST_IDLE`.

Top module: `relcam_bitserial`

## Requirements
- R1: While reset is held and after its release, `match_eq`, `match_lt`, `match_gt` and `srch_done` are all 0 and no word counts as written.
- R2: A write in `ST_IDLE` stores `wr_data` at the word whose index is `wr_idx` and marks that word written. A later search with a reference equal to that value sets the word's bit in `match_eq`.
- R3: For each bit, the flag pair (P,N) is (0,1) when the reference bit equals the stored bit, (1,1) for reference 0 and stored 1, and (0,0) for reference 1 and stored 0. P XOR N gives equality, P AND N gives reference-below, and NOR gives reference-above. A word is reported equal only if no bit position differs.
- R4: Bits are scanned from the most significant bit down. The first differing bit fixes the word's order state, and later bits never change it.
- R5: At `srch_done`, each written word has exactly one of its bits set in `match_eq`, `match_lt` (reference < stored, unsigned) or `match_gt` (reference > stored).
- R6: `srch_done` is high for exactly one cycle. It rises WORD_BITS+1 clock edges after the edge that samples the start. The vectors hold their values until the next done.
- R7: A write and a search start in the same `ST_IDLE` cycle both take effect, and that search compares against the newly written word.
- R8: While a search runs (`ST_SCAN`, `ST_RESULT`), writes and search starts are ignored. Stored data, the reference and the running search are unchanged.
- R9: A word that was never written reports 0 in all three vectors, so a search over an empty table reports all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, honoured only in `ST_IDLE` |
| wr_idx | input | IDX_W | Index of the word to write |
| wr_data | input | WORD_BITS | Value to store |
| srch_start | input | 1 | Search start, honoured only in `ST_IDLE` |
| srch_ref | input | WORD_BITS | Reference word, captured with the start |
| match_eq | output | NUM_WORDS | Per word: stored equals reference |
| match_lt | output | NUM_WORDS | Per word: reference below stored |
| match_gt | output | NUM_WORDS | Per word: reference above stored |
| srch_done | output | 1 | One-cycle strobe marking new result vectors |

## Verification
A word write and a search start can arrive in the same cycle. The bench drives both on one idle edge, with the reference equal to the new data, and expects the written word to come back equal. It also writes during a running scan and issues a second start there. It then judges the outcome at the next done: the results must match the original reference against the original table, and no extra done may follow. Around these cases, every reference value is swept over several table contents, including a partly written one. Each outcome is compared with plain unsigned comparison done in the bench.

// File: rtl/relcam_pkg.sv
package relcam_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_RESULT = 2'd2
    } scan_state_e;

    typedef enum logic [1:0] {
        WO_UNDECIDED = 2'd0,
        WO_LESS      = 2'd1,
        WO_GREATER   = 2'd2
    } word_order_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } flag_pair_t;

    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
    } bit_verdict_t;

endpackage

// File: rtl/relcam_store.sv
module relcam_store #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_BITS = 3,
    parameter int IDX_W     = 2,
    parameter int BIT_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 lock,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic [BIT_W-1:0]     bit_sel,
    output logic [NUM_WORDS-1:0] col_bits,
    output logic [NUM_WORDS-1:0] valid
);

    logic [NUM_WORDS-1:0][WORD_BITS-1:0] words_q;
    logic [NUM_WORDS-1:0]                valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
            valid_q <= '0;
        end else if (wr_en && !lock) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (wr_idx == IDX_W'(w)) begin
                    words_q[w] <= wr_data;
                    valid_q[w] <= 1'b1;
                end
            end
        end
    end

    // one column slice of the array, the bit under test for every word
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_col
        assign col_bits[g] = words_q[g][bit_sel];
    end

    assign valid = valid_q;

    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock) |=> ($stable(words_q) && $stable(valid_q))); // R8

endmodule

// File: rtl/relcam_bitcmp.sv
module relcam_bitcmp
    import relcam_pkg::*;
(
    input  logic         ref_bit,
    input  logic         stored_bit,
    output bit_verdict_t verdict
);

    flag_pair_t pair;

    always_comb begin
        // two-flag code: match (0,1), ref<stored (1,1), ref>stored (0,0)
        pair.pos   = ~ref_bit & stored_bit;
        pair.neg   = ~ref_bit | stored_bit;
        verdict.eq = pair.pos ^ pair.neg;
        verdict.lt = pair.pos & pair.neg;
        verdict.gt = ~(pair.pos | pair.neg);
    end

endmodule

// File: rtl/relcam_word_res.sv
module relcam_word_res
    import relcam_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  bit_verdict_t verdict,
    output word_order_e  order
);

    word_order_e order_q;
    word_order_e order_d;

    always_comb begin
        order_d = order_q;
        if (clear) begin
            order_d = WO_UNDECIDED;
        end else if (step && (order_q == WO_UNDECIDED)) begin
            case ({verdict.eq, verdict.lt, verdict.gt})
                3'b100:  order_d = WO_UNDECIDED;
                3'b010:  order_d = WO_LESS;
                3'b001:  order_d = WO_GREATER;
                default: order_d = order_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) order_q <= WO_UNDECIDED;
        else        order_q <= order_d;
    end

    assign order = order_q;

    AST_DECISION_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((order_q != WO_UNDECIDED) && !clear) |=> $stable(order_q)); // R4

endmodule

// File: rtl/relcam_bitserial.sv
module relcam_bitserial
    import relcam_pkg::*;
#(
    parameter int  NUM_WORDS = 4,
    parameter int  WORD_BITS = 3,
    localparam int IDX_W     = (NUM_WORDS < 2) ? 1 : $clog2(NUM_WORDS),
    localparam int BIT_W     = (WORD_BITS < 2) ? 1 : $clog2(WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic                 srch_start,
    input  logic [WORD_BITS-1:0] srch_ref,
    output logic [NUM_WORDS-1:0] match_eq,
    output logic [NUM_WORDS-1:0] match_lt,
    output logic [NUM_WORDS-1:0] match_gt,
    output logic                 srch_done
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

    scan_state_e            state_q;
    scan_state_e            state_d;
    logic [BIT_W-1:0]       bit_idx_q;
    logic [WORD_BITS-1:0]   ref_q;
    logic                   busy;
    logic                   start_go;
    logic                   ref_bit;
    logic [NUM_WORDS-1:0]   col_bits;
    logic [NUM_WORDS-1:0]   valid;
    bit_verdict_t           verdict [NUM_WORDS];
    word_order_e            order   [NUM_WORDS];

    assign busy     = (state_q != ST_IDLE);
    assign start_go = (state_q == ST_IDLE) && srch_start;
    assign ref_bit  = ref_q[bit_idx_q];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (srch_start) state_d = ST_SCAN;
            ST_SCAN:   if (bit_idx_q == '0) state_d = ST_RESULT;
            ST_RESULT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // reference capture and bit walk, most significant bit first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= '0;
            bit_idx_q <= '0;
        end else if (start_go) begin
            ref_q     <= srch_ref;
            bit_idx_q <= LAST_BIT;
        end else if ((state_q == ST_SCAN) && (bit_idx_q != '0)) begin
            bit_idx_q <= bit_idx_q - 1'b1;
        end
    end

    relcam_store #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_BITS (WORD_BITS),
        .IDX_W     (IDX_W),
        .BIT_W     (BIT_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .lock     (busy),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .bit_sel  (bit_idx_q),
        .col_bits (col_bits),
        .valid    (valid)
    );

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        relcam_bitcmp cmp_i (
            .ref_bit    (ref_bit),
            .stored_bit (col_bits[g]),
            .verdict    (verdict[g])
        );

        relcam_word_res res_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (start_go),
            .step    (state_q == ST_SCAN),
            .verdict (verdict[g]),
            .order   (order[g])
        );
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_eq  <= '0;
            match_lt  <= '0;
            match_gt  <= '0;
            srch_done <= 1'b0;
        end else begin
            srch_done <= (state_q == ST_RESULT);
            if (state_q == ST_RESULT) begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    match_eq[w] <= valid[w] && (order[w] == WO_UNDECIDED);
                    match_lt[w] <= valid[w] && (order[w] == WO_LESS);
                    match_gt[w] <= valid[w] && (order[w] == WO_GREATER);
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        srch_done |=> !srch_done); // R6

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        srch_done |-> (((match_eq & match_lt) | (match_eq & match_gt) | (match_lt & match_gt)) == '0)); // R5

    AST_UNWRITTEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        srch_done |-> (((match_eq | match_lt | match_gt) & ~valid) == '0)); // R9

    AST_BUSY_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && srch_start) |=> $stable(ref_q)); // R8

    AST_SCAN_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (bit_idx_q <= LAST_BIT)); // R4

endmodule

// File: tb/relcam_bitserial_tb_top.sv
module relcam_bitserial_tb_top;

    localparam int W  = 4;
    localparam int N  = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [N-1:0]  wr_data;
    logic          srch_start;
    logic [N-1:0]  srch_ref;
    logic [W-1:0]  match_eq, match_lt, match_gt;
    logic          srch_done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    logic [N-1:0] mdl    [W];
    logic         mvalid [W];

    always #5 clk = ~clk;

    relcam_bitserial #(.NUM_WORDS(W), .WORD_BITS(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .srch_start (srch_start),
        .srch_ref   (srch_ref),
        .match_eq   (match_eq),
        .match_lt   (match_lt),
        .match_gt   (match_gt),
        .srch_done  (srch_done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void expect_vecs(input logic [N-1:0] r, output logic [W-1:0] e,
                                        output logic [W-1:0] l, output logic [W-1:0] g);
        e = '0; l = '0; g = '0;
        for (int i = 0; i < W; i++) begin
            if (mvalid[i]) begin
                if (r == mdl[i])     e[i] = 1'b1;
                else if (r < mdl[i]) l[i] = 1'b1;
                else                 g[i] = 1'b1;
            end
        end
    endfunction

    task automatic write_word(input int idx, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[idx] = d; mvalid[idx] = 1'b1;
    endtask

    // waits for done after the start edge; returns edges counted
    task automatic wait_done(output int lat);
        lat = 0;
        while (!srch_done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_vecs(input logic [N-1:0] r, input string tag);
        logic [W-1:0] e, l, g;
        expect_vecs(r, e, l, g);
        check(match_eq == e, {tag, " R3 eq"}, int'(match_eq), int'(e));
        check(match_lt == l, {tag, " R4 lt"}, int'(match_lt), int'(l));
        check(match_gt == g, {tag, " R5 gt"}, int'(match_gt), int'(g));
        check(((match_eq & match_lt) | (match_eq & match_gt) | (match_lt & match_gt)) == '0,
              {tag, " R5 exclusive"}, int'({match_eq, match_lt, match_gt}), 0);
    endtask

    task automatic run_search(input logic [N-1:0] r, input string tag);
        int lat;
        @(negedge clk);
        srch_start = 1'b1; srch_ref = r;
        @(negedge clk);
        srch_start = 1'b0;
        wait_done(lat);
        check(lat == N + 1, {tag, " R6 latency"}, lat, N + 1);
        check_vecs(r, tag);
    endtask

    initial begin
        logic [W-1:0] held_eq, held_lt, held_gt;
        int lat;
        int extra;
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        srch_start = 1'b0; srch_ref = '0;
        for (int i = 0; i < W; i++) begin mdl[i] = '0; mvalid[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check({match_eq, match_lt, match_gt, srch_done} == '0, "R1 reset outputs",
              int'({match_eq, match_lt, match_gt, srch_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({match_eq, match_lt, match_gt, srch_done} == '0, "R1 after release",
              int'({match_eq, match_lt, match_gt, srch_done}), 0);

        // R9: empty table
        run_search(3'd5, "R9 empty");

        // R2 / R9: partly written table, full reference sweep
        write_word(0, 3'd6);
        write_word(2, 3'd1);
        run_search(3'd6, "R2 readback");
        check(match_eq[0] == 1'b1, "R2 written word equal", int'(match_eq[0]), 1);
        for (int r = 0; r < (1 << N); r++) run_search(N'(r), "R9 partial");

        // near-exhaustive sweep over several full tables
        for (int s = 0; s < 6; s++) begin
            for (int i = 0; i < W; i++) begin
                if (s == 5) write_word(i, (i % 2 == 0) ? 3'd0 : 3'd7);
                else        write_word(i, N'((s * 3 + i * 5 + s * i) % (1 << N)));
            end
            for (int r = 0; r < (1 << N); r++) run_search(N'(r), "sweep");
        end

        // R6: vectors held after done
        run_search(3'd3, "R6 pre-hold");
        held_eq = match_eq; held_lt = match_lt; held_gt = match_gt;
        repeat (4) @(negedge clk);
        check({match_eq, match_lt, match_gt} == {held_eq, held_lt, held_gt}, "R6 held",
              int'({match_eq, match_lt, match_gt}), int'({held_eq, held_lt, held_gt}));

        // R7: write and start in the same idle cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(3); wr_data = 3'd4;
        srch_start = 1'b1; srch_ref = 3'd4;
        @(negedge clk);
        wr_en = 1'b0; srch_start = 1'b0;
        mdl[3] = 3'd4; mvalid[3] = 1'b1;
        wait_done(lat);
        check(lat == N + 1, "R7 latency", lat, N + 1);
        check(match_eq[3] == 1'b1, "R7 new word seen", int'(match_eq[3]), 1);
        check_vecs(3'd4, "R7");

        // R8: write and restart while busy are dropped
        write_word(1, 3'd2);
        @(negedge clk);
        srch_start = 1'b1; srch_ref = 3'd5;
        @(negedge clk);
        srch_start = 1'b1; srch_ref = 3'd0;
        wr_en = 1'b1; wr_idx = IW'(1); wr_data = 3'd5;
        @(negedge clk);
        srch_start = 1'b0; wr_en = 1'b0;
        lat = 1;
        while (!srch_done && lat < 20) begin @(negedge clk); lat++; end
        check(lat == N + 1, "R8 latency", lat, N + 1);
        check(match_gt[1] == 1'b1 && match_eq[1] == 1'b0, "R8 busy write dropped",
              int'({match_eq[1], match_gt[1]}), 1);
        check_vecs(3'd5, "R8");
        extra = 0;
        repeat (N + 3) begin @(negedge clk); if (srch_done) extra++; end
        check(extra == 0, "R8 busy start dropped", extra, 0);
        run_search(3'd2, "R8 table intact");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule